// File: doc/BRIEF.md
# Dual Auto-Reload Down-Counter Timer

This block holds two independent down-counters and a pair of watchdog storage words behind a small register bus. The bus takes one access per clock. A write is applied on the rising edge in the cycle that `bus_we` is high. Read data is combinational from the addressed register and the current state. Each counter has a reload word and a live count word.

Each counter is controlled by two bits in one shared control word. The enable bit for counter n sits at bit 2n and the auto-reload bit at bit 2n+1. An enabled counter loses one on every clock. When it reaches zero, it either starts again from its reload word, which gives a period of reload+1 cycles, or it parks at zero. Software may overwrite the live count at any moment.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every register reads zero and both counters are disabled.
- R2: Registers sit at word-aligned byte offsets: control 0x00, counter 0 reload 0x10, counter 0 count 0x14, counter 1 reload 0x18, counter 1 count 0x1C, watchdog reload 0x20, watchdog count 0x24. Each offset reads back what was last written there, 32 bits wide with all-ones the largest value.
- R3: In the control word, bit 2n enables counter n and bit 2n+1 selects auto-reload for counter n. Bits 31:4 ignore writes and read zero.
- R4: An enabled counter whose count is not zero decrements by exactly one per clock.
- R5: An enabled auto-reload counter at zero takes its reload value on the next clock, giving a period of reload+1 cycles.
- R6: An enabled one-shot counter (auto-reload bit 0) at zero stays at zero.
- R7: A disabled counter keeps its count unchanged.
- R8: A bus write to a count register sets that count on the next edge and overrides a decrement or reload in the same cycle.
- R9: Offsets 0x04, 0x08, 0x0C and all offsets above 0x24 read zero, and writes to them change no register.
- R10: The two counters run independently; the bits of one counter never affect the other.
- R11: Writing a reload register leaves the live count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; counters step on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 6 | Byte offset; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |

## Verification
The assertions assume that the bus presents one settled address and write strobe per cycle. They also assume that a write to a count register is the only outside source of a count change, so every other count step must follow from the control bits. The stimulus issues exactly one access per clock and changes the bus only on falling edges. It waits out the internal reset release before its first write, so no write is lost to the synchronizer.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  // word indices (byte offset >> 2)
  localparam int unsigned CTRL_IDX    = 0;
  localparam int unsigned CH_BASE_IDX = 4;

  // per-channel control pair: en at bit 0, auto_rl at bit 1
  typedef struct packed {
    logic auto_rl;
    logic en;
  } chan_cfg_t;

endpackage

// File: rtl/dtmr_rst_sync.sv
module dtmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dtmr_word.sv
module dtmr_word #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word_q
);

  logic [WORD_W-1:0] word_d;

  always_comb word_d = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (wr_en) word_q <= word_d;
  end

  a_r2_word_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> word_q == $past(wdata));

  a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(word_q));

endmodule

// File: rtl/dtmr_ctrl.sv
module dtmr_ctrl #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CNT_W-1:0]    wdata,
  output logic [2*NUM_CH-1:0] ctrl_q
);

  localparam int unsigned CFG_W = 2 * NUM_CH;

  logic [CFG_W-1:0] ctrl_d;

  always_comb ctrl_d = wdata[CFG_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_d;
  end

  a_r3_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_q == $past(wdata[CFG_W-1:0]));

  a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chan_cfg_t        cfg,
  input  logic             rl_we,
  input  logic             val_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] value_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             at_zero;
  logic             val_upd;
  logic [CNT_W-1:0] value_d;

  always_comb begin
    at_zero = (value_q == '0);
    val_upd = val_we | cfg.en;
    if (val_we)       value_d = wdata;
    else if (at_zero) value_d = cfg.auto_rl ? reload_q : '0;
    else              value_d = value_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     reload_q <= '0;
    else if (rl_we) reload_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value_q <= '0;
    else if (val_upd) value_q <= value_d;
  end

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    val_we |=> value_q == $past(wdata));

  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (!val_we && cfg.en && value_q != '0) |=> value_q == $past(value_q) - ONE);

  a_r5_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!val_we && cfg.en && cfg.auto_rl && value_q == '0) |=> value_q == $past(reload_q));

  a_r6_one_shot_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (!val_we && cfg.en && !cfg.auto_rl && value_q == '0) |=> value_q == '0);

  a_r7_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!val_we && !cfg.en) |=> $stable(value_q));

  a_r11_reload_store: assert property (@(posedge clk) disable iff (!rst_n)
    rl_we |=> reload_q == $past(wdata));

endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import dtmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata
);

  localparam int unsigned IDX_W     = ADDR_W - 2;
  localparam int unsigned CFG_W     = 2 * NUM_CH;
  localparam int unsigned WD_RL_IDX = CH_BASE_IDX + 2 * NUM_CH;
  localparam int unsigned WD_VL_IDX = WD_RL_IDX + 1;

  logic             rst_sync_n;
  logic [IDX_W-1:0] widx;
  logic [CFG_W-1:0] ctrl_q;
  logic [CNT_W-1:0] ch_rl  [NUM_CH];
  logic [CNT_W-1:0] ch_val [NUM_CH];
  logic [CNT_W-1:0] wd_rl_q;
  logic [CNT_W-1:0] wd_vl_q;
  logic             is_reserved;

  assign widx = bus_addr[ADDR_W-1:2];

  dtmr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dtmr_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (bus_we && (widx == IDX_W'(CTRL_IDX))),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_q)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dtmr_channel #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .cfg      (chan_cfg_t'(ctrl_q[2*i +: 2])),
      .rl_we    (bus_we && (widx == IDX_W'(CH_BASE_IDX + 2*i))),
      .val_we   (bus_we && (widx == IDX_W'(CH_BASE_IDX + 2*i + 1))),
      .wdata    (bus_wdata),
      .reload_q (ch_rl[i]),
      .value_q  (ch_val[i])
    );
  end

  dtmr_word #(.WORD_W(CNT_W)) u_wd_rl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (bus_we && (widx == IDX_W'(WD_RL_IDX))),
    .wdata  (bus_wdata),
    .word_q (wd_rl_q)
  );

  dtmr_word #(.WORD_W(CNT_W)) u_wd_vl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (bus_we && (widx == IDX_W'(WD_VL_IDX))),
    .wdata  (bus_wdata),
    .word_q (wd_vl_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (widx == IDX_W'(CTRL_IDX))  bus_rdata = CNT_W'(ctrl_q);
    if (widx == IDX_W'(WD_RL_IDX)) bus_rdata = wd_rl_q;
    if (widx == IDX_W'(WD_VL_IDX)) bus_rdata = wd_vl_q;
    for (int k = 0; k < NUM_CH; k++) begin
      if (widx == IDX_W'(CH_BASE_IDX + 2*k))     bus_rdata = ch_rl[k];
      if (widx == IDX_W'(CH_BASE_IDX + 2*k + 1)) bus_rdata = ch_val[k];
    end
  end

  assign is_reserved = ((widx != IDX_W'(CTRL_IDX)) && (widx < IDX_W'(CH_BASE_IDX)))
                    || (widx > IDX_W'(WD_VL_IDX));

  a_r9_reserved_reads_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_reserved |-> bus_rdata == '0);

  a_r3_upper_ctrl_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (widx == IDX_W'(CTRL_IDX)) |-> bus_rdata[CNT_W-1:CFG_W] == '0);

endmodule

// File: tb/dual_down_timer_bench.sv
module dual_down_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  string phase = "R1 reset";

  // behavioural reference state
  logic [31:0] m_ctrl;
  logic [31:0] m_rl  [2];
  logic [31:0] m_val [2];
  logic [31:0] m_wdr;
  logic [31:0] m_wdv;

  dual_down_timer u_dual_down_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model_read(input logic [5:0] a);
    case (a[5:2])
      4'd0:    return m_ctrl;
      4'd4:    return m_rl[0];
      4'd5:    return m_val[0];
      4'd6:    return m_rl[1];
      4'd7:    return m_val[1];
      4'd8:    return m_wdr;
      4'd9:    return m_wdv;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step(input logic we, input logic [5:0] a, input logic [31:0] d);
    logic [31:0] nv [2];
    for (int n = 0; n < 2; n++) begin
      nv[n] = m_val[n];
      if (m_ctrl[2*n]) begin
        if (m_val[n] == 0) nv[n] = m_ctrl[2*n+1] ? m_rl[n] : 32'h0;
        else               nv[n] = m_val[n] - 1;
      end
    end
    if (we) begin
      case (a[5:2])
        4'd0: m_ctrl = d & 32'hF;
        4'd4: m_rl[0] = d;
        4'd5: nv[0] = d;
        4'd6: m_rl[1] = d;
        4'd7: nv[1] = d;
        4'd8: m_wdr = d;
        4'd9: m_wdv = d;
        default: ;
      endcase
    end
    m_val[0] = nv[0];
    m_val[1] = nv[1];
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, bus_addr, act, exp);
    end
  endtask

  // one bus cycle: compare against the model every clock, optionally a fixed value too
  task automatic cyc(input logic we, input logic [5:0] a, input logic [31:0] d,
                     input bit has_exp, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
    check(phase, bus_rdata, model_read(a));
    if (has_exp) check(tag, bus_rdata, exp);
    @(posedge clk);
    model_step(we, a, d);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 32'h0, "");
  endtask

  task automatic rd(input logic [5:0] a);
    cyc(1'b0, a, 32'h0, 1'b0, 32'h0, "");
  endtask

  task automatic rdx(input logic [5:0] a, input logic [31:0] exp, input string tag);
    cyc(1'b0, a, 32'h0, 1'b1, exp, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    m_ctrl = 0; m_rl[0] = 0; m_rl[1] = 0; m_val[0] = 0; m_val[1] = 0; m_wdr = 0; m_wdv = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // idle cycles cover the internal reset release
    for (int i = 0; i < 4; i++) rd(6'h00);

    phase = "R1 reset";
    for (int a = 0; a < 64; a += 4) rdx(6'(a), 32'h0, "R1 reset value");

    phase = "R2 map";
    wr(6'h10, 32'h1111_0001);
    wr(6'h18, 32'h2222_0002);
    wr(6'h20, 32'hA5A5_5A5A);
    wr(6'h24, 32'h0F0F_F0F0);
    rdx(6'h10, 32'h1111_0001, "R2 t0 reload");
    rdx(6'h18, 32'h2222_0002, "R2 t1 reload");
    rdx(6'h20, 32'hA5A5_5A5A, "R2 wd reload");
    rdx(6'h24, 32'h0F0F_F0F0, "R2 wd count");
    phase = "R11 reload keeps count";
    rdx(6'h14, 32'h0, "R11 t0 count");
    rdx(6'h1C, 32'h0, "R11 t1 count");

    phase = "R9 reserved";
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h0C, 32'hFFFF_FFFF);
    wr(6'h2C, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    rdx(6'h04, 32'h0, "R9 0x04");
    rdx(6'h0C, 32'h0, "R9 0x0C");
    rdx(6'h3C, 32'h0, "R9 0x3C");
    rdx(6'h00, 32'h0, "R9 ctrl untouched");
    rdx(6'h10, 32'h1111_0001, "R9 reload untouched");
    rdx(6'h14, 32'h0, "R9 count untouched");

    phase = "R3 control";
    wr(6'h00, 32'hFFFF_FFF0);
    rdx(6'h00, 32'h0, "R3 upper bits");
    wr(6'h00, 32'h0000_0005);
    rdx(6'h00, 32'h5, "R3 enable bits");
    wr(6'h00, 32'h0);

    phase = "R7 disabled";
    wr(6'h14, 32'h5);
    rdx(6'h14, 32'h5, "R7 hold");
    rdx(6'h14, 32'h5, "R7 hold");
    rdx(6'h14, 32'h5, "R7 hold");
    phase = "R10 independent";
    wr(6'h00, 32'h4);
    rdx(6'h14, 32'h5, "R10 t0 ignores t1 enable");
    rdx(6'h14, 32'h5, "R10 t0 ignores t1 enable");
    wr(6'h00, 32'h0);

    phase = "R4 R6 one-shot";
    wr(6'h14, 32'h4);
    wr(6'h00, 32'h1);
    rdx(6'h14, 32'h4, "R4 count");
    rdx(6'h14, 32'h3, "R4 count");
    rdx(6'h14, 32'h2, "R4 count");
    rdx(6'h14, 32'h1, "R4 count");
    rdx(6'h14, 32'h0, "R6 zero");
    rdx(6'h14, 32'h0, "R6 parked");
    rdx(6'h14, 32'h0, "R6 parked");

    phase = "R5 auto-reload";
    wr(6'h00, 32'h0);
    wr(6'h10, 32'h2);
    wr(6'h14, 32'h1);
    wr(6'h00, 32'h3);
    rdx(6'h14, 32'h1, "R5 period");
    rdx(6'h14, 32'h0, "R5 period");
    rdx(6'h14, 32'h2, "R5 reload");
    rdx(6'h14, 32'h1, "R5 period");
    rdx(6'h14, 32'h0, "R5 period");
    rdx(6'h14, 32'h2, "R5 reload");
    rd(6'h14);

    phase = "R8 write priority";
    wr(6'h14, 32'h40);
    rdx(6'h14, 32'h40, "R8 write over reload");
    rdx(6'h14, 32'h3F, "R8 then decrement");
    wr(6'h14, 32'h80);
    rdx(6'h14, 32'h80, "R8 write over decrement");

    phase = "R10 both running";
    wr(6'h18, 32'hFFFF_FFFF);
    wr(6'h1C, 32'h1);
    wr(6'h00, 32'hF);
    rdx(6'h1C, 32'h1, "R10 t1 count");
    rdx(6'h1C, 32'h0, "R10 t1 zero");
    rdx(6'h1C, 32'hFFFF_FFFF, "R5 all-ones reload");
    rdx(6'h1C, 32'hFFFF_FFFE, "R4 from all-ones");
    rdx(6'h00, 32'hF, "R3 both enabled");
    for (int i = 0; i < 8; i++) rd(i[0] ? 6'h14 : 6'h1C);
    rdx(6'h24, 32'h0F0F_F0F0, "R2 wd count static");

    finish_run();
  end

endmodule